// File: doc/BRIEF.md
# Receive Frame Admission Controller

This block sits between a MAC receive FIFO and the frame buffer memory. When a start-of-frame word shows up, it decides whether the frame may enter. For multicast frames that decision depends on how full the multicast forwarding FIFO is. An admitted frame then takes one free buffer handle from an external handle pool. Each frame word is written into buffer memory at the slot that handle selects.

At end of frame there are two outcomes:
- A good frame is committed. The block presents a descriptor carrying the handle, the byte length and a multicast flag, and that descriptor acts as the switching request.
- A frame marked bad, or one longer than a buffer, is abandoned. Its handle is released back to the pool, and no descriptor is produced.

A frame that cannot enter is consumed and thrown away. It never holds a handle.

The word input and the descriptor output are valid/ready streams. A word moves when `in_valid` and `in_ready` are both high on a rising edge. `in_ready` may depend on `in_valid`, `in_sof` and internal state. A descriptor moves when `desc_valid` and `desc_ready` are both high. While `desc_ready` is low, the descriptor is held and input stalls. The handle pool, memory write, release and configuration pins are plain signals with no handshake.

Top module: `rx_admit_ctrl`

## Requirements
- R1: After reset, `desc_valid`, `mem_we`, `rel_valid` and `hp_take` are all low.
- R2: A handle is taken (`hp_take`) only in a cycle where `hp_valid` is high, and only for an admitted frame. No word of a frame is written to memory before its handle has been taken.
- R3: Suppose the pool offers no handle (`hp_valid` low) in the cycle after an admitted start of frame. The whole frame is then consumed with no memory write, no release and no descriptor.
- R4: After the end-of-frame word of a good frame has been written, `desc_valid` rises. The descriptor carries the handle, the sum of `in_nbytes` over all words, and the multicast flag. It stays valid and unchanged until `desc_ready` is high. Input is not accepted meanwhile.
- R5: An end-of-frame word with `in_bad` high asserts `rel_valid` with the frame's handle in the same cycle it is accepted. No descriptor follows.
- R6: A frame of more than `MAX_WORDS` words writes only its first `MAX_WORDS` words. At its end it is released as in R5, never committed.
- R7: Word i of a frame (counting from 0) is written to address handle*`MAX_WORDS` + i. `MAX_WORDS` must be a power of two.
- R8: A frame with `in_mcast` low is never refused by the multicast policy. With `cfg_ipmc_priv` low, a multicast frame is refused only when `mcq_level` >= `MCQ_DEPTH`.
- R9: With `cfg_ipmc_priv` high, an ordinary multicast frame (`in_ipmc` low) is refused when `mcq_level` is greater than a threshold. `cfg_mc_thr` codes 0, 1, 2 and 3 select a threshold of 1/4, 1/2, 3/4 and 7/8 of `MCQ_DEPTH`.
- R10: With `cfg_ipmc_priv` high, an IP multicast frame (`in_mcast` and `in_ipmc` high) is refused only when `mcq_level` >= `MCQ_DEPTH`.
- R11: In idle, a word without `in_sof` is accepted and discarded with no memory write. The policy inputs and configuration are sampled with the start-of-frame word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ipmc_priv | input | 1 | IP multicast privilege enable |
| cfg_mc_thr | input | 2 | Ordinary multicast threshold code |
| mcq_level | input | $clog2(MCQ_DEPTH+1) | Multicast forwarding FIFO occupancy |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted |
| in_data | input | DATA_W | Frame word |
| in_nbytes | input | $clog2(DATA_W/8+1) | Valid bytes in this word |
| in_sof | input | 1 | First word of frame |
| in_eof | input | 1 | Last word of frame |
| in_bad | input | 1 | Frame bad, valid with in_eof |
| in_mcast | input | 1 | Multicast frame, valid with in_sof |
| in_ipmc | input | 1 | IP multicast frame, valid with in_sof |
| hp_valid | input | 1 | Pool offers a free handle |
| hp_handle | input | HANDLE_W | Offered handle |
| hp_take | output | 1 | Offered handle taken this cycle |
| mem_we | output | 1 | Buffer memory write strobe |
| mem_addr | output | HANDLE_W+$clog2(MAX_WORDS) | Buffer memory word address |
| mem_wdata | output | DATA_W | Buffer memory write data |
| rel_valid | output | 1 | Release handle to pool |
| rel_handle | output | HANDLE_W | Handle being released |
| desc_valid | output | 1 | Descriptor / switching request valid |
| desc_ready | input | 1 | Descriptor accepted |
| desc_handle | output | HANDLE_W | Descriptor handle |
| desc_len | output | $clog2(MAX_WORDS*DATA_W/8+1) | Frame length in bytes |
| desc_mcast | output | 1 | Frame was multicast |

## Verification
The embedded assertions check the following on every cycle:
- a handle is never taken without an offer;
- a memory write only happens while a handle is held;
- a held descriptor does not change under back-pressure;
- a release is never followed by a descriptor;
- the word counter never passes the buffer size.

Only the bench scenarios can show the rest, by comparing outputs against a model:
- the admission decision at each threshold boundary;
- the exact address and data of every write;
- the accumulated byte length;
- discarding when the pool is empty;
- the handling of overlong and stray words.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_STORE,
    ST_COMMIT,
    ST_DROP
  } rfa_state_e;

  // eighths of the FIFO depth selected by each threshold code
  function automatic int thr_eighths(input int code);
    case (code)
      0: return 2;
      1: return 4;
      2: return 6;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/rfa_mc_policy.sv
module rfa_mc_policy #(
  parameter int MCQ_DEPTH = 16,
  localparam int LVW = $clog2(MCQ_DEPTH + 1)
) (
  input  logic           is_mc,
  input  logic           is_ipmc,
  input  logic           priv_en,
  input  logic [1:0]     thr_code,
  input  logic [LVW-1:0] level,
  output logic           admit
);
  logic [LVW-1:0] thr_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_thr
    assign thr_tab[g] = LVW'((MCQ_DEPTH * rfa_pkg::thr_eighths(g)) / 8);
  end

  logic full, over_thr;
  assign full     = (level >= LVW'(MCQ_DEPTH));
  assign over_thr = (level > thr_tab[thr_code]);

  always_comb begin
    if (!is_mc)                    admit = 1'b1;
    else if (full)                 admit = 1'b0;
    else if (priv_en && !is_ipmc)  admit = !over_thr;
    else                           admit = 1'b1;
  end
endmodule

// File: rtl/rfa_word_ctr.sv
module rfa_word_ctr #(
  parameter int MAX_WORDS = 16,
  parameter int NBW = 3,
  parameter int LW = 7,
  localparam int CW = $clog2(MAX_WORDS + 1),
  localparam int IW = $clog2(MAX_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [NBW-1:0] nbytes,
  output logic [IW-1:0] widx,
  output logic          full,
  output logic          ovf,
  output logic [LW-1:0] len
);
  logic [CW-1:0] cnt;

  assign widx = cnt[IW-1:0];
  assign full = (cnt == CW'(MAX_WORDS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
      len <= '0;
    end else if (clr) begin
      cnt <= '0;
      ovf <= 1'b0;
      len <= '0;
    end else if (adv) begin
      len <= len + LW'(nbytes);
      if (full) ovf <= 1'b1;
      else      cnt <= cnt + 1'b1;
    end
  end

  // R6: the word slot counter never runs past the buffer size
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX_WORDS));
  // R6: once overflowed, the frame stays overflowed until a new handle
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !clr |=> ovf);
endmodule

// File: rtl/rx_admit_ctrl.sv
module rx_admit_ctrl #(
  parameter int DATA_W    = 32,
  parameter int HANDLE_W  = 6,
  parameter int MAX_WORDS = 16,
  parameter int MCQ_DEPTH = 16,
  localparam int BPW = DATA_W / 8,
  localparam int NBW = $clog2(BPW + 1),
  localparam int IW  = $clog2(MAX_WORDS),
  localparam int AW  = HANDLE_W + IW,
  localparam int LW  = $clog2(MAX_WORDS * BPW + 1),
  localparam int LVW = $clog2(MCQ_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_ipmc_priv,
  input  logic [1:0]          cfg_mc_thr,
  input  logic [LVW-1:0]      mcq_level,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_data,
  input  logic [NBW-1:0]      in_nbytes,
  input  logic                in_sof,
  input  logic                in_eof,
  input  logic                in_bad,
  input  logic                in_mcast,
  input  logic                in_ipmc,
  input  logic                hp_valid,
  input  logic [HANDLE_W-1:0] hp_handle,
  output logic                hp_take,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                rel_valid,
  output logic [HANDLE_W-1:0] rel_handle,
  output logic                desc_valid,
  input  logic                desc_ready,
  output logic [HANDLE_W-1:0] desc_handle,
  output logic [LW-1:0]       desc_len,
  output logic                desc_mcast
);
  import rfa_pkg::*;

  rfa_state_e st, nxt;
  logic [HANDLE_W-1:0] handle_q;
  logic mc_q, admit, full, ovf, abandon;
  logic [IW-1:0] widx;
  logic [LW-1:0] len;

  rfa_mc_policy #(.MCQ_DEPTH(MCQ_DEPTH)) u_policy (
    .is_mc(in_mcast), .is_ipmc(in_ipmc), .priv_en(cfg_ipmc_priv),
    .thr_code(cfg_mc_thr), .level(mcq_level), .admit(admit)
  );

  rfa_word_ctr #(.MAX_WORDS(MAX_WORDS), .NBW(NBW), .LW(LW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(hp_take),
    .adv(st == ST_STORE && in_valid), .nbytes(in_nbytes),
    .widx(widx), .full(full), .ovf(ovf), .len(len)
  );

  assign abandon = in_bad || ovf || full;

  always_comb begin
    nxt        = st;
    in_ready   = 1'b0;
    hp_take    = 1'b0;
    mem_we     = 1'b0;
    rel_valid  = 1'b0;
    desc_valid = 1'b0;
    case (st)
      ST_IDLE: if (in_valid) begin
        if (in_sof) nxt = admit ? ST_ACQ : ST_DROP;
        else        in_ready = 1'b1;
      end
      ST_ACQ: begin
        hp_take = hp_valid;
        nxt     = hp_valid ? ST_STORE : ST_DROP;
      end
      ST_STORE: begin
        in_ready = 1'b1;
        if (in_valid) begin
          mem_we = !full;
          if (in_eof) begin
            rel_valid = abandon;
            nxt       = abandon ? ST_IDLE : ST_COMMIT;
          end
        end
      end
      ST_COMMIT: begin
        desc_valid = 1'b1;
        if (desc_ready) nxt = ST_IDLE;
      end
      ST_DROP: begin
        in_ready = 1'b1;
        if (in_valid && in_eof) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      handle_q <= '0;
      mc_q     <= 1'b0;
    end else begin
      st <= nxt;
      if (hp_take) handle_q <= hp_handle;
      if (st == ST_IDLE && in_valid && in_sof) mc_q <= in_mcast;
    end
  end

  assign mem_addr    = {handle_q, widx};
  assign mem_wdata   = in_data;
  assign rel_handle  = handle_q;
  assign desc_handle = handle_q;
  assign desc_len    = len;
  assign desc_mcast  = mc_q;

  // ownership tracker used only by the checks below
  logic own_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                                 own_q <= 1'b0;
    else if (hp_take)                           own_q <= 1'b1;
    else if (rel_valid || (desc_valid && desc_ready)) own_q <= 1'b0;
  end

  // R2: a handle is taken only when one is offered
  a_r2_take_offered: assert property (@(posedge clk) disable iff (!rst_n)
    hp_take |-> hp_valid);
  // R2: no memory write without a held handle
  a_r2_write_owned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> own_q);
  // R4: descriptor held steady under back-pressure
  a_r4_desc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_handle)
      && $stable(desc_len) && $stable(desc_mcast));
  // R4: input stalls while a descriptor waits
  a_r4_stall: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> !in_ready);
  // R5: a released frame never produces a descriptor
  a_r5_rel_no_desc: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |=> !desc_valid);
endmodule

// File: tb/rx_admit_ctrl_test.sv
module rx_admit_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXW = 16;
  localparam int QD = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_ipmc_priv = 0; logic [1:0] cfg_mc_thr = 0; logic [4:0] mcq_level = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_bad = 0, in_mcast = 0, in_ipmc = 0;
  logic [31:0] in_data = 0; logic [2:0] in_nbytes = 0;
  logic hp_valid = 0; logic [5:0] hp_handle = 0;
  logic desc_ready = 0;
  logic in_ready, hp_take, mem_we, rel_valid, desc_valid, desc_mcast;
  logic [9:0] mem_addr; logic [31:0] mem_wdata;
  logic [5:0] rel_handle, desc_handle; logic [6:0] desc_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_admit_ctrl uut (.*);

  int n_chk = 0, n_bad = 0;
  int wn, rn, dn, tn; int rh, dh, dl, dm;
  logic [9:0] wa [0:63]; logic [31:0] wd [0:63];
  logic [31:0] fd [0:31]; int fb [0:31];

  always @(negedge clk) begin
    if (mem_we) begin
      if (wn < 64) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; end
      wn++;
    end
    if (rel_valid) begin rn++; rh = rel_handle; end
    if (desc_valid && desc_ready) begin dn++; dh = desc_handle; dl = desc_len; dm = desc_mcast; end
    if (hp_take) tn++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  function automatic bit exp_admit(bit mc, bit ip, bit priv, int thr, int lvl);
    int t = (thr == 0) ? QD/4 : (thr == 1) ? QD/2 : (thr == 2) ? 3*QD/4 : 7*QD/8;
    if (!mc) return 1;
    if (lvl >= QD) return 0;
    if (priv && !ip && lvl > t) return 0;
    return 1;
  endfunction

  task automatic send_word(input logic [31:0] d, input int nb, input bit sof, input bit eof,
                           input bit bad, input bit mc, input bit ip);
    in_valid = 1; in_data = d; in_nbytes = 3'(nb); in_sof = sof; in_eof = eof;
    in_bad = bad; in_mcast = mc; in_ipmc = ip;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0; in_sof = 0; in_eof = 0; in_bad = 0;
  endtask

  task automatic run_frame(input int n, input bit mc, input bit ip, input bit bad,
                           input bit pool, input int h, input bit priv, input int thr,
                           input int lvl, input int hold);
    int elen = 0; bit adm, commit, rel; int ewr;
    wn = 0; rn = 0; dn = 0; tn = 0;
    cfg_ipmc_priv = priv; cfg_mc_thr = 2'(thr); mcq_level = 5'(lvl);
    hp_valid = pool; hp_handle = 6'(h);
    for (int i = 0; i < n; i++) begin
      fd[i] = $urandom; fb[i] = 1 + ($urandom % 4); elen += fb[i];
    end
    for (int i = 0; i < n; i++) begin
      send_word(fd[i], fb[i], i == 0, i == n-1, bad && i == n-1, mc, ip);
      if ($urandom % 4 == 0) begin @(posedge clk); #1; end
    end
    adm = exp_admit(mc, ip, priv, thr, lvl) && pool;
    rel = adm && (bad || n > MAXW);
    commit = adm && !rel;
    ewr = adm ? ((n > MAXW) ? MAXW : n) : 0;
    @(negedge clk);
    check(desc_valid == commit, "R4/R5 desc_valid after eof", desc_valid, commit);
    if (commit) begin
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        check(desc_valid && desc_handle == 6'(h), "R4 held descriptor", desc_handle, h);
        check(in_ready == 0, "R4 input stalled", in_ready, 0);
      end
      @(posedge clk); #1; desc_ready = 1;
      @(posedge clk); #1; desc_ready = 0;
    end
    @(negedge clk);
    check(tn == (exp_admit(mc, ip, priv, thr, lvl) && pool ? 1 : 0), "R2/R8/R9/R10 handle take", tn, adm);
    check(wn == ewr, "R2/R3/R6 write count", wn, ewr);
    for (int i = 0; i < ewr && i < 64; i++) begin
      check(wa[i] == 10'(h*MAXW + i), "R7 write address", wa[i], h*MAXW + i);
      check(wd[i] == fd[i], "R7 write data", wd[i], fd[i]);
    end
    check(rn == (rel ? 1 : 0), "R5/R6 release count", rn, rel);
    if (rel) check(rh == h, "R5 release handle", rh, h);
    check(dn == (commit ? 1 : 0), "R4 descriptor count", dn, commit);
    if (commit) begin
      check(dh == h, "R4 desc handle", dh, h);
      check(dl == elen, "R4 desc length", dl, elen);
      check(dm == mc, "R4 desc mcast", dm, mc);
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(posedge clk); #1;
    @(negedge clk);
    check(!desc_valid && !mem_we && !rel_valid && !hp_take, "R1 reset outputs",
          {desc_valid, mem_we, rel_valid, hp_take}, 0);
    @(posedge clk); #1; rst_n = 1;
    // R11: stray word in idle
    wn = 0;
    send_word(32'hDEAD, 4, 0, 0, 0, 0, 0);
    @(negedge clk);
    check(wn == 0, "R11 stray word not written", wn, 0);
    // directed
    run_frame(3, 0, 0, 0, 1, 5, 0, 0, 16, 2);   // R8 unicast never refused
    run_frame(4, 0, 0, 0, 0, 7, 0, 0, 0, 0);    // R3 empty pool
    run_frame(2, 0, 0, 1, 1, 9, 0, 0, 0, 0);    // R5 bad frame
    run_frame(MAXW, 0, 0, 0, 1, 11, 0, 0, 0, 1);   // R6 exactly full
    run_frame(MAXW+2, 0, 0, 0, 1, 12, 0, 0, 0, 0); // R6 overlong
    run_frame(1, 0, 0, 0, 1, 63, 0, 0, 0, 0);   // R7 top handle, single word
    run_frame(2, 1, 0, 0, 1, 3, 0, 0, 15, 0);   // R8 mcast priv off below full
    run_frame(2, 1, 0, 0, 1, 3, 0, 0, 16, 0);   // R8 mcast priv off full
    run_frame(2, 1, 0, 0, 1, 4, 1, 1, 8, 0);    // R9 at threshold 1/2
    run_frame(2, 1, 0, 0, 1, 4, 1, 1, 9, 0);    // R9 above threshold 1/2
    run_frame(2, 1, 0, 0, 1, 4, 1, 0, 5, 0);    // R9 above 1/4
    run_frame(2, 1, 0, 0, 1, 4, 1, 3, 14, 0);   // R9 at 7/8
    run_frame(2, 1, 0, 0, 1, 4, 1, 2, 13, 0);   // R9 above 3/4
    run_frame(2, 1, 1, 0, 1, 6, 1, 0, 15, 1);   // R10 ipmc near full
    run_frame(2, 1, 1, 0, 1, 6, 1, 0, 16, 0);   // R10 ipmc full
    // constrained random
    for (int f = 0; f < 80; f++) begin
      int n = 1 + ($urandom % (MAXW + 2));
      run_frame(n, $urandom % 2, $urandom % 2, ($urandom % 5) == 0, ($urandom % 6) != 0,
                $urandom % 64, $urandom % 2, $urandom % 4, $urandom % 17, $urandom % 4);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule